// File: doc/BRIEF.md
# Transmit Frame Timing Generator

This block keeps the transmit-side frame position of a link master. It counts words within a basic frame, basic frames within a hyperframe, hyperframes within a radio frame, and radio frames. It marks the hyperframe and radio-frame boundaries with pulses. A strobe marks one basic frame at a programmable position inside each radio frame.

A rising edge on an external sync input realigns all counters to a radio-frame boundary a fixed seven cycles later. With no sync edge, the counters run freely. Each cycle the block outputs a transmit word. Auxiliary data replaces the internal control word bit by bit wherever the auxiliary mask is set. In the comma slot the fixed comma word always goes out. Any mask bit raised in the comma slot is reported on an error output.

Top module: `tx_frame_timer`

## Requirements
- R1: While `rst_n` is low, the word index, basic-frame index, hyperframe number, radio-frame number and `tx_err` are all 0.
- R2: With no resync, the word index counts up each cycle and wraps from WORDS_PER_BF-1 to 0. The basic-frame index steps when the word index wraps, and wraps from BF_PER_HF-1 to 0. The hyperframe number steps when the basic-frame index wraps, and wraps from HF_PER_RF-1 to 0.
- R3: A sync edge is a clock edge at which `sync_in` is sampled high after being sampled low at the previous edge. If a sync edge occurs at edge n and no further sync edge occurs at edges n+1 to n+7, then after edge n+7 the word index, basic-frame index and hyperframe number are 0, and the radio-frame number is its previous value plus 1. Holding `sync_in` high makes only one edge.
- R4: A sync edge during the seven-cycle wait restarts the wait from that edge. The earlier edge then causes no realignment.
- R5: `tx_hf_start` is high exactly when the word index and the basic-frame index are both 0. `tx_rf_start` is high exactly when, in addition, the hyperframe number is 0.
- R6: `tx_start` is high exactly when hyperframe number × BF_PER_HF + basic-frame index equals `start_ofs`. It therefore stays high for all words of that basic frame. An offset of 0 selects basic frame 0 of hyperframe 0.
- R7: Outside the comma slot, `tx_word` = (internal & ~`aux_mask`) | (`aux_data` & `aux_mask`). The internal word is {hyperframe number, basic-frame index, word index}, zero-extended, with the word index in the low bits.
- R8: In the comma slot (basic-frame index 0 and hyperframe number 0), `tx_word` is 8'hBC zero-extended, whatever the values of `aux_mask` and `aux_data`.
- R9: `tx_err` is high for the single cycle after a clock edge at which the comma slot held and `aux_mask` was nonzero. At all other times it is low.
- R10: The radio-frame number steps when the hyperframe number wraps or on a realignment, and wraps from 2^RFN_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | External radio-frame sync, rising edge realigns |
| start_ofs | input | OFS_W | Start strobe position in basic frames from the radio-frame boundary |
| aux_data | input | DATA_W | Auxiliary data word |
| aux_mask | input | DATA_W | Per-bit select of auxiliary data |
| tx_seq | output | $clog2(WORDS_PER_BF) | Word index in basic frame |
| tx_bf | output | $clog2(BF_PER_HF) | Basic-frame index in hyperframe |
| tx_hfn | output | $clog2(HF_PER_RF) | Hyperframe number |
| tx_rfn | output | RFN_W | Radio-frame number |
| tx_hf_start | output | 1 | Hyperframe start pulse |
| tx_rf_start | output | 1 | Radio-frame start pulse |
| tx_start | output | 1 | Start strobe |
| tx_word | output | DATA_W | Merged transmit word |
| tx_err | output | 1 | Comma-slot mask violation |

## Verification
The counters, pulses and strobe change at each clock edge. `tx_word` follows its inputs within the same cycle. `tx_err` is due one edge after the slot that caused it, and a realignment is due seven edges after the sync edge. The bench model advances its state at each rising edge from the inputs held since the previous falling edge. It takes the error flag from the state that held before that edge. It compares every output a quarter period after the edge, when registered and combinational results have both settled. Stimulus changes only on falling edges.

// File: rtl/tx_frame_timer.sv
module tx_frame_timer #(
  parameter int WORDS_PER_BF = 16,
  parameter int BF_PER_HF    = 256,
  parameter int HF_PER_RF    = 150,
  parameter int RFN_W        = 12,
  parameter int DATA_W       = 32,
  parameter int OFS_W        = 16,
  localparam int SEQ_W = $clog2(WORDS_PER_BF),
  localparam int BF_W  = $clog2(BF_PER_HF),
  localparam int HFN_W = $clog2(HF_PER_RF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic [OFS_W-1:0]  start_ofs,
  input  logic [DATA_W-1:0] aux_data,
  input  logic [DATA_W-1:0] aux_mask,
  output logic [SEQ_W-1:0]  tx_seq,
  output logic [BF_W-1:0]   tx_bf,
  output logic [HFN_W-1:0]  tx_hfn,
  output logic [RFN_W-1:0]  tx_rfn,
  output logic              tx_hf_start,
  output logic              tx_rf_start,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_word,
  output logic              tx_err
);
  localparam int SYNC_LAT = 7;
  localparam int IW = HFN_W + BF_W + SEQ_W;

  logic       sync_q, pend;
  logic [2:0] lat_cnt;

  wire seq_last  = tx_seq == SEQ_W'(WORDS_PER_BF - 1);
  wire bf_last   = tx_bf  == BF_W'(BF_PER_HF - 1);
  wire hfn_last  = tx_hfn == HFN_W'(HF_PER_RF - 1);
  wire sync_edge = sync_in & ~sync_q;
  wire fire      = pend && lat_cnt == 3'(SYNC_LAT - 1) && !sync_edge;
  wire comma     = tx_bf == '0 && tx_hfn == '0;

  wire [31:0] bf_pos = 32'(tx_hfn) * 32'(BF_PER_HF) + 32'(tx_bf);
  wire [DATA_W-1:0] int_word   = {{(DATA_W-IW){1'b0}}, tx_hfn, tx_bf, tx_seq};
  wire [DATA_W-1:0] comma_word = {{(DATA_W-8){1'b0}}, 8'hBC};

  assign tx_hf_start = tx_seq == '0 && tx_bf == '0;
  assign tx_rf_start = tx_hf_start && tx_hfn == '0;
  assign tx_start    = bf_pos == 32'(start_ofs);
  assign tx_word     = comma ? comma_word : ((int_word & ~aux_mask) | (aux_data & aux_mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      pend    <= 1'b0;
      lat_cnt <= '0;
      tx_seq  <= '0;
      tx_bf   <= '0;
      tx_hfn  <= '0;
      tx_rfn  <= '0;
      tx_err  <= 1'b0;
    end else begin
      sync_q <= sync_in;
      tx_err <= comma && (|aux_mask);

      if (sync_edge) begin
        pend    <= 1'b1;
        lat_cnt <= '0;
      end else if (fire) begin
        pend <= 1'b0;
      end else if (pend) begin
        lat_cnt <= lat_cnt + 3'd1;
      end

      if (fire) begin
        tx_seq <= '0;
        tx_bf  <= '0;
        tx_hfn <= '0;
        tx_rfn <= tx_rfn + 1'b1;
      end else begin
        tx_seq <= seq_last ? '0 : tx_seq + 1'b1;
        if (seq_last) begin
          tx_bf <= bf_last ? '0 : tx_bf + 1'b1;
          if (bf_last) begin
            tx_hfn <= hfn_last ? '0 : tx_hfn + 1'b1;
            if (hfn_last) tx_rfn <= tx_rfn + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tx_frame_timer_chk.sv
module tx_frame_timer_chk #(
  parameter int WORDS_PER_BF = 16,
  parameter int BF_PER_HF    = 256,
  parameter int HF_PER_RF    = 150,
  parameter int RFN_W        = 12,
  parameter int DATA_W       = 32,
  localparam int SEQ_W = $clog2(WORDS_PER_BF),
  localparam int BF_W  = $clog2(BF_PER_HF),
  localparam int HFN_W = $clog2(HF_PER_RF)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] aux_mask,
  input logic [SEQ_W-1:0]  tx_seq,
  input logic [BF_W-1:0]   tx_bf,
  input logic [HFN_W-1:0]  tx_hfn,
  input logic [RFN_W-1:0]  tx_rfn,
  input logic              tx_hf_start,
  input logic              tx_rf_start,
  input logic [DATA_W-1:0] tx_word,
  input logic              tx_err
);
  p_seq_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_seq == SEQ_W'(WORDS_PER_BF - 1) |=> tx_seq == '0);

  p_rf_in_hf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rf_start |-> tx_hf_start && tx_hfn == '0);

  p_comma_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bf == '0 && tx_hfn == '0) |-> tx_word[7:0] == 8'hBC);

  p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bf == '0 && tx_hfn == '0 && aux_mask != '0) |=> tx_err);

  p_err_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_bf == '0 && tx_hfn == '0 && aux_mask != '0) |=> !tx_err);

  p_rfn_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rfn != $past(tx_rfn) |-> tx_rf_start);
endmodule

bind tx_frame_timer tx_frame_timer_chk #(
  .WORDS_PER_BF(WORDS_PER_BF), .BF_PER_HF(BF_PER_HF), .HF_PER_RF(HF_PER_RF),
  .RFN_W(RFN_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .aux_mask(aux_mask), .tx_seq(tx_seq), .tx_bf(tx_bf),
  .tx_hfn(tx_hfn), .tx_rfn(tx_rfn), .tx_hf_start(tx_hf_start), .tx_rf_start(tx_rf_start),
  .tx_word(tx_word), .tx_err(tx_err)
);

// File: tb/tx_frame_timer_bench.sv
module tx_frame_timer_bench;
  localparam int W = 4, BF = 4, HF = 5, RW = 4, DW = 16, OW = 8;

  logic clk = 0, rst_n = 0, sync_in = 0;
  logic [OW-1:0] start_ofs = '0;
  logic [DW-1:0] aux_data = '0, aux_mask = '0;
  logic [1:0] tx_seq, tx_bf;
  logic [2:0] tx_hfn;
  logic [RW-1:0] tx_rfn;
  logic tx_hf_start, tx_rf_start, tx_start, tx_err;
  logic [DW-1:0] tx_word;

  tx_frame_timer #(.WORDS_PER_BF(W), .BF_PER_HF(BF), .HF_PER_RF(HF), .RFN_W(RW),
                   .DATA_W(DW), .OFS_W(OW)) u_tx_frame_timer (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .start_ofs(start_ofs),
    .aux_data(aux_data), .aux_mask(aux_mask), .tx_seq(tx_seq), .tx_bf(tx_bf),
    .tx_hfn(tx_hfn), .tx_rfn(tx_rfn), .tx_hf_start(tx_hf_start),
    .tx_rf_start(tx_rf_start), .tx_start(tx_start), .tx_word(tx_word), .tx_err(tx_err));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, n_realign = 0;
  bit done = 0;
  int m_seq = 0, m_bf = 0, m_hfn = 0, m_rfn = 0, m_due = 0;
  bit m_sq = 0, m_err = 0;

  task automatic cmp(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_seq = 0; m_bf = 0; m_hfn = 0; m_rfn = 0; m_due = 0; m_sq = 0; m_err = 0;
    end else begin
      bit edge_now, go;
      m_err = (m_bf == 0 && m_hfn == 0) && aux_mask != 0;
      edge_now = sync_in && !m_sq;
      m_sq = sync_in;
      go = 0;
      if (edge_now) m_due = 7;
      else if (m_due > 0) begin
        m_due--;
        go = (m_due == 0);
      end
      if (go) begin
        n_realign++;
        m_seq = 0; m_bf = 0; m_hfn = 0; m_rfn = (m_rfn + 1) % (1 << RW);
      end else begin
        m_seq++;
        if (m_seq == W) begin
          m_seq = 0; m_bf++;
          if (m_bf == BF) begin
            m_bf = 0; m_hfn++;
            if (m_hfn == HF) begin
              m_hfn = 0; m_rfn = (m_rfn + 1) % (1 << RW);
            end
          end
        end
      end
    end
    #5;
    if (!done) begin
      int iw, ew;
      bit cs;
      string rq;
      rq = rst_n ? "R2/R3/R4" : "R1";
      cs = (m_bf == 0 && m_hfn == 0);
      iw = (m_hfn << 4) | (m_bf << 2) | m_seq;
      ew = cs ? 'hBC : ((iw & ~int'(aux_mask)) | (int'(aux_data) & int'(aux_mask))) & 'hFFFF;
      cmp(rq, "word index", tx_seq, m_seq);
      cmp(rq, "basic frame", tx_bf, m_bf);
      cmp(rq, "hyperframe", tx_hfn, m_hfn);
      cmp(rst_n ? "R10" : "R1", "radio frame", tx_rfn, m_rfn);
      cmp("R5", "hf pulse", tx_hf_start, m_seq == 0 && m_bf == 0);
      cmp("R5", "rf pulse", tx_rf_start, m_seq == 0 && m_bf == 0 && m_hfn == 0);
      cmp("R6", "start strobe", tx_start, (m_hfn * BF + m_bf) == int'(start_ofs));
      cmp(cs ? "R8" : "R7", "tx word", tx_word, ew);
      cmp(rst_n ? "R9" : "R1", "error", tx_err, m_err);
    end
  end

  task automatic run(int n, int mask_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sync_in  = 0;
      aux_data = DW'($urandom);
      aux_mask = ($urandom % 100 < mask_pct) ? DW'($urandom) : '0;
    end
  endtask

  task automatic pulse(int hold);
    @(negedge clk);
    sync_in = 1;
    for (int i = 1; i < hold; i++) @(negedge clk);
    @(negedge clk);
    sync_in = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    run(200, 50);
    pulse(1); run(30, 30);                      // R3 single-cycle sync
    pulse(1); run(3, 0); pulse(1); run(30, 30); // R4 restart inside window
    pulse(30); run(20, 30);                     // R3 held level, one edge
    start_ofs = 7;  run(200, 40);               // R6
    start_ofs = 19; run(200, 40);               // R6 last position
    start_ofs = 25; run(100, 40);               // R6 unreachable
    start_ofs = 0;  run(1500, 20);              // R10 radio-frame wrap
    run(78, 0); pulse(1); run(40, 100);         // R3 near boundary, R9
    if (n_realign < 4) begin
      n_bad++;
      $display("FAIL R3 realign count: actual %0d expected >=4", n_realign);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    done = 1;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule